// File: doc/BRIEF.md
# Hashed Segmented Payload Signature Matcher

This block scans packet payload one byte per clock for signatures that have been cut into fixed-length segments. It holds the last `SEG_LEN` bytes of the current packet in a window, hashes that window with a shift-and-add function, and reads a rule memory at the hash address. A segment that opens a signature is a head entry. Every later segment sits at its own hash address and carries a link back to the address of the segment before it. Several signatures that begin with the same segment therefore store that segment once, and each continuation links back to it.

A single chain pointer records the address of the most recently matched segment. After a non-final segment matches, the block waits until exactly `SEG_LEN` further bytes have arrived. It then requires the window to hit an entry whose link equals the pointer. When the final segment of a signature matches, the block raises a one-cycle alert carrying the rule number, but only if that rule's bit is set in the header-match vector supplied with the byte. A host fills the rule memory through a write port before traffic starts.

Top module: `payload_sig_matcher`

## Requirements
- R1: After reset `alert` is low and every rule memory entry is invalid, so no payload produces an alert until entries are written.
- R2: A cycle with `wr_en` high stores all entry fields at `wr_addr`, replacing what was there. Segment byte k (k=0 first in payload order) sits at bits [8k+7:8k] of `wr_seg`.
- R3: On every accepted byte the window holds the last `SEG_LEN` bytes of the current packet, with the newest last. Its address is the sum over k of byte_k shifted left by (SEG_LEN-1-k), truncated to `ADDR_W` bits. A lookup happens only once `SEG_LEN` bytes of the packet have arrived.
- R4: A window that equals a valid head entry marked final raises `alert` in the cycle after the byte that completes it, with `alert_rule` equal to that entry's rule id.
- R5: A valid head entry not marked final opens a chain. The byte that arrives exactly `SEG_LEN` bytes later must complete a window that hits a valid non-head entry whose link equals the address of the previous segment. If that entry is final, the alert is raised with its rule id. Otherwise the chain moves to it.
- R6: Several continuation entries may link to one head entry, and each of them completes its own signature.
- R7: A chain whose boundary window does not hit a suitable continuation is dropped. That same byte may still open or complete a head entry.
- R8: While a chain is waiting for its next boundary, head hits are ignored.
- R9: A byte with `pkt_start` high begins a new packet. It empties the window fill and drops any chain, so no signature spans two packets.
- R10: An alert is raised only when bit `alert_rule` of `hdr_match`, as sampled with the completing byte, is set. Otherwise the completed signature produces nothing.
- R11: Cycles with `byte_valid` low change no window, fill or chain state and produce no alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | A payload byte is present this cycle |
| pkt_start | input | 1 | The present byte is the first of a packet |
| byte_data | input | 8 | Payload byte |
| hdr_match | input | NUM_RULES (256) | Per-rule header lookup result |
| wr_en | input | 1 | Write one rule memory entry |
| wr_addr | input | ADDR_W (9) | Entry address |
| wr_seg | input | SEG_LEN*8 (40) | Segment bytes |
| wr_valid | input | 1 | Entry valid |
| wr_head | input | 1 | Entry opens a signature |
| wr_link | input | ADDR_W (9) | Address of the preceding segment |
| wr_last | input | 1 | Entry ends a signature |
| wr_rule | input | RULE_W (8) | Rule id of the signature |
| alert | output | 1 | A signature completed with its rule enabled |
| alert_rule | output | RULE_W (8) | Rule id of the alert |

## Verification
The bench builds the block with its defaults: 5-byte segments, a 9-bit hash that gives 512 entries, and 256 rules. Rule ids above 127 therefore exercise the upper half of the header vector. The test segments occupy distinct hash addresses. These values let three-segment chains, a head shared by two continuations, overlap between a failed boundary and a fresh head, and head windows that fall inside a pending chain all occur within a few bytes. A long stretch of random bytes drawn from the signature alphabet, with random packet starts and header vectors, is then compared against the behavioural model on every clock.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] pm_byte_t;
endpackage

// File: rtl/pm_window.sv
module pm_window import pm_pkg::*; #(
  parameter int SEG_LEN = 5,
  parameter int HASH_W = 9,
  localparam int WIN_W = SEG_LEN * BYTE_W,
  localparam int FILL_W = $clog2(SEG_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic              pkt_start,
  input  pm_byte_t          byte_data,
  output logic [WIN_W-1:0]  win_next,
  output logic              win_full,
  output logic [HASH_W-1:0] win_hash
);
  // shift-and-add hash: oldest byte carries the largest shift
  function automatic logic [HASH_W-1:0] seg_hash(input logic [WIN_W-1:0] w);
    logic [31:0] acc;
    acc = '0;
    for (int k = 0; k < SEG_LEN; k++)
      acc = acc + (32'(w[BYTE_W*k +: BYTE_W]) << (SEG_LEN - 1 - k));
    return acc[HASH_W-1:0];
  endfunction

  logic [WIN_W-1:0]  win_q;
  logic [FILL_W-1:0] fill_q, fill_next;

  generate
    if (SEG_LEN == 1) begin : g_one
      assign win_next = byte_data;
    end else begin : g_many
      assign win_next = {byte_data, win_q[WIN_W-1:BYTE_W]};
    end
  endgenerate

  always_comb begin
    if (pkt_start)                      fill_next = FILL_W'(1);
    else if (fill_q == FILL_W'(SEG_LEN)) fill_next = fill_q;
    else                                 fill_next = fill_q + FILL_W'(1);
  end

  assign win_full = byte_valid && (fill_next == FILL_W'(SEG_LEN));
  assign win_hash = seg_hash(win_next);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (byte_valid) begin
      win_q  <= win_next;
      fill_q <= fill_next;
    end
  end
endmodule

// File: rtl/pm_rule_mem.sv
module pm_rule_mem import pm_pkg::*; #(
  parameter int SEG_LEN = 5,
  parameter int ADDR_W = 9,
  parameter int RULE_W = 8,
  localparam int WIN_W = SEG_LEN * BYTE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIN_W-1:0]  wr_seg,
  input  logic              wr_valid,
  input  logic              wr_head,
  input  logic [ADDR_W-1:0] wr_link,
  input  logic              wr_last,
  input  logic [RULE_W-1:0] wr_rule,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIN_W-1:0]  rd_seg,
  output logic              rd_valid,
  output logic              rd_head,
  output logic [ADDR_W-1:0] rd_link,
  output logic              rd_last,
  output logic [RULE_W-1:0] rd_rule
);
  logic [WIN_W-1:0]  seg_mem  [DEPTH];
  logic [ADDR_W-1:0] link_mem [DEPTH];
  logic [RULE_W-1:0] rule_mem [DEPTH];
  logic [DEPTH-1:0]  vld_q, head_q, last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      last_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_addr]  <= wr_valid;
      head_q[wr_addr] <= wr_head;
      last_q[wr_addr] <= wr_last;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      seg_mem[wr_addr]  <= wr_seg;
      link_mem[wr_addr] <= wr_link;
      rule_mem[wr_addr] <= wr_rule;
    end
  end

  assign rd_valid = vld_q[rd_addr];
  assign rd_head  = head_q[rd_addr];
  assign rd_last  = last_q[rd_addr];
  assign rd_seg   = seg_mem[rd_addr];
  assign rd_link  = link_mem[rd_addr];
  assign rd_rule  = rule_mem[rd_addr];
endmodule

// File: rtl/pm_chain.sv
module pm_chain import pm_pkg::*; #(
  parameter int SEG_LEN = 5,
  parameter int ADDR_W = 9,
  parameter int NUM_RULES = 256,
  localparam int RULE_W = $clog2(NUM_RULES),
  localparam int WIN_W = SEG_LEN * BYTE_W,
  localparam int POS_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_valid,
  input  logic                 pkt_start,
  input  logic                 win_full,
  input  logic [WIN_W-1:0]     win_next,
  input  logic [ADDR_W-1:0]    win_hash,
  input  logic [WIN_W-1:0]     e_seg,
  input  logic                 e_valid,
  input  logic                 e_head,
  input  logic [ADDR_W-1:0]    e_link,
  input  logic                 e_last,
  input  logic [RULE_W-1:0]    e_rule,
  input  logic [NUM_RULES-1:0] hdr_match,
  output logic                 alert,
  output logic [RULE_W-1:0]    alert_rule,
  output logic                 ev_step_ok,
  output logic                 ev_head_ok,
  output logic                 ev_chain_fail,
  output logic                 ev_found,
  output logic                 chain_active,
  output logic [POS_W-1:0]     chain_pos
);
  logic              active_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [POS_W-1:0]  pos_q;
  logic              live, at_bound, counting, win_eq, advance;

  assign live     = active_q && !pkt_start;
  assign at_bound = live && (pos_q == POS_W'(SEG_LEN - 1));
  assign counting = live && !at_bound;
  assign win_eq   = e_valid && (e_seg == win_next);

  // continuation: boundary window hits a non-head entry linked to the pointer
  assign ev_step_ok    = byte_valid && win_full && at_bound && win_eq && !e_head && (e_link == ptr_q);
  assign ev_chain_fail = byte_valid && at_bound && !ev_step_ok;
  // heads are looked at only when no chain is waiting for its boundary
  assign ev_head_ok    = byte_valid && win_full && win_eq && e_head && !counting;
  assign ev_found      = (ev_step_ok || ev_head_ok) && e_last;
  assign advance       = (ev_step_ok || ev_head_ok) && !e_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      ptr_q      <= '0;
      pos_q      <= '0;
      alert      <= 1'b0;
      alert_rule <= '0;
    end else begin
      alert <= ev_found && hdr_match[e_rule];
      if (ev_found) alert_rule <= e_rule;
      if (byte_valid) begin
        if (advance) begin
          active_q <= 1'b1;
          ptr_q    <= win_hash;
          pos_q    <= '0;
        end else if (counting) begin
          pos_q <= pos_q + POS_W'(1);
        end else begin
          active_q <= 1'b0;
        end
      end
    end
  end

  assign chain_active = active_q;
  assign chain_pos    = pos_q;
endmodule

// File: rtl/payload_sig_matcher.sv
module payload_sig_matcher import pm_pkg::*; #(
  parameter int SEG_LEN = 5,
  parameter int ADDR_W = 9,
  parameter int NUM_RULES = 256,
  localparam int RULE_W = $clog2(NUM_RULES),
  localparam int WIN_W = SEG_LEN * BYTE_W,
  localparam int POS_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_valid,
  input  logic                 pkt_start,
  input  logic [7:0]           byte_data,
  input  logic [NUM_RULES-1:0] hdr_match,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [WIN_W-1:0]     wr_seg,
  input  logic                 wr_valid,
  input  logic                 wr_head,
  input  logic [ADDR_W-1:0]    wr_link,
  input  logic                 wr_last,
  input  logic [RULE_W-1:0]    wr_rule,
  output logic                 alert,
  output logic [RULE_W-1:0]    alert_rule
);
  logic [WIN_W-1:0]  win_next;
  logic              win_full;
  logic [ADDR_W-1:0] win_hash;
  logic [WIN_W-1:0]  e_seg;
  logic              e_valid, e_head, e_last;
  logic [ADDR_W-1:0] e_link;
  logic [RULE_W-1:0] e_rule;
  logic              ev_step_ok, ev_head_ok, ev_chain_fail, ev_found, chain_active;
  logic [POS_W-1:0]  chain_pos;

  pm_window #(.SEG_LEN(SEG_LEN), .HASH_W(ADDR_W)) u_window (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .pkt_start(pkt_start),
    .byte_data(byte_data), .win_next(win_next), .win_full(win_full), .win_hash(win_hash)
  );

  pm_rule_mem #(.SEG_LEN(SEG_LEN), .ADDR_W(ADDR_W), .RULE_W(RULE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_seg(wr_seg),
    .wr_valid(wr_valid), .wr_head(wr_head), .wr_link(wr_link), .wr_last(wr_last),
    .wr_rule(wr_rule), .rd_addr(win_hash), .rd_seg(e_seg), .rd_valid(e_valid),
    .rd_head(e_head), .rd_link(e_link), .rd_last(e_last), .rd_rule(e_rule)
  );

  pm_chain #(.SEG_LEN(SEG_LEN), .ADDR_W(ADDR_W), .NUM_RULES(NUM_RULES)) u_chain (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .pkt_start(pkt_start),
    .win_full(win_full), .win_next(win_next), .win_hash(win_hash),
    .e_seg(e_seg), .e_valid(e_valid), .e_head(e_head), .e_link(e_link),
    .e_last(e_last), .e_rule(e_rule), .hdr_match(hdr_match),
    .alert(alert), .alert_rule(alert_rule), .ev_step_ok(ev_step_ok),
    .ev_head_ok(ev_head_ok), .ev_chain_fail(ev_chain_fail), .ev_found(ev_found),
    .chain_active(chain_active), .chain_pos(chain_pos)
  );
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int SEG_LEN = 5,
  parameter int NUM_RULES = 256,
  localparam int RULE_W = $clog2(NUM_RULES),
  localparam int POS_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 byte_valid,
  input logic                 pkt_start,
  input logic [NUM_RULES-1:0] hdr_match,
  input logic                 alert,
  input logic [RULE_W-1:0]    alert_rule,
  input logic                 ev_step_ok,
  input logic                 ev_head_ok,
  input logic                 ev_chain_fail,
  input logic                 ev_found,
  input logic                 chain_active,
  input logic [POS_W-1:0]     chain_pos
);
  logic [NUM_RULES-1:0] hdr_d;
  always_ff @(posedge clk) hdr_d <= hdr_match;

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !alert);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> !alert);

  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    alert |-> hdr_d[alert_rule]);

  p_step_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step_ok && !ev_found |=> chain_active && (chain_pos == '0));

  p_fail_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chain_fail && !ev_head_ok |=> !chain_active);

  p_pos_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chain_active |-> (int'(chain_pos) < SEG_LEN));

  generate
    if (SEG_LEN > 1) begin : g_start
      p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && pkt_start |=> !chain_active && !alert);
    end
  endgenerate
endmodule

bind payload_sig_matcher pm_checker #(.SEG_LEN(SEG_LEN), .NUM_RULES(NUM_RULES)) u_pm_checker (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .pkt_start(pkt_start),
  .hdr_match(hdr_match), .alert(alert), .alert_rule(alert_rule),
  .ev_step_ok(ev_step_ok), .ev_head_ok(ev_head_ok), .ev_chain_fail(ev_chain_fail),
  .ev_found(ev_found), .chain_active(chain_active), .chain_pos(chain_pos)
);

// File: tb/test_payload_sig_matcher.sv
`timescale 1ns/1ps
module test_payload_sig_matcher;
  localparam int SEG_LEN = 5;
  localparam int ADDR_W = 9;
  localparam int NUM_RULES = 256;
  localparam int RULE_W = 8;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_valid = 1'b0, pkt_start = 1'b0;
  logic [7:0] byte_data = '0;
  logic [NUM_RULES-1:0] hdr_match = '1;
  logic wr_en = 1'b0, wr_valid = 1'b0, wr_head = 1'b0, wr_last = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, wr_link = '0;
  logic [SEG_LEN*8-1:0] wr_seg = '0;
  logic [RULE_W-1:0] wr_rule = '0;
  logic alert;
  logic [RULE_W-1:0] alert_rule;

  always #10 clk = ~clk;

  payload_sig_matcher i_payload_sig_matcher (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .pkt_start(pkt_start),
    .byte_data(byte_data), .hdr_match(hdr_match), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_seg(wr_seg), .wr_valid(wr_valid), .wr_head(wr_head), .wr_link(wr_link),
    .wr_last(wr_last), .wr_rule(wr_rule), .alert(alert), .alert_rule(alert_rule)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit finished = 0;

  // reference table and state
  bit    m_vld [DEPTH];
  bit    m_head [DEPTH];
  bit    m_last [DEPTH];
  int    m_link [DEPTH];
  int    m_rule [DEPTH];
  string m_seg [DEPTH];
  byte   hist[$];
  bit    m_act = 0;
  int    m_ptr = 0, m_cnt = 0;
  bit    exp_alert = 0;
  int    exp_rule = 0;

  function automatic int ref_hash(string s);
    int h = 0;
    for (int k = 0; k < SEG_LEN; k++) h = h * 2 + int'(s[k]);
    return h % DEPTH;
  endfunction

  function automatic void model_byte(byte b, bit start);
    int h, c;
    bit full, eq, step, counting, at_b, found;
    string w;
    found = 0;
    if (start) begin hist.delete(); m_act = 0; end
    hist.push_back(b);
    if (hist.size() > SEG_LEN) void'(hist.pop_front());
    full = (hist.size() == SEG_LEN);
    h = 0; eq = 0;
    if (full) begin
      w = "";
      for (int k = 0; k < SEG_LEN; k++) w = {w, string'(hist[k])};
      h = ref_hash(w);
      eq = m_vld[h] && (m_seg[h] == w);
    end
    c = m_act ? m_cnt + 1 : 0;
    counting = m_act && (c < SEG_LEN);
    at_b = m_act && (c == SEG_LEN);
    step = full && at_b && eq && !m_head[h] && (m_link[h] == m_ptr);
    if (step && m_last[h]) begin found = 1; m_act = 0; end
    else if (step) begin m_ptr = h; m_cnt = 0; m_act = 1; end
    else if (counting) m_cnt = c;
    else m_act = 0;
    if (!step && !counting && full && eq && m_head[h]) begin
      if (m_last[h]) found = 1;
      else begin m_act = 1; m_ptr = h; m_cnt = 0; end
    end
    exp_alert = found && hdr_match[m_rule[h]];
    if (exp_alert) exp_rule = m_rule[h];
  endfunction

  task automatic compare();
    checks++;
    if (alert !== exp_alert || (exp_alert && alert_rule !== RULE_W'(exp_rule))) begin
      fails++;
      $display("FAIL %s: alert=%0b rule=%0d expected alert=%0b rule=%0d at %0t",
               cur_req, alert, alert_rule, exp_alert, exp_rule, $time);
    end
  endtask

  task automatic step(bit v, bit s, byte b);
    @(negedge clk);
    compare();
    byte_valid = v; pkt_start = s; byte_data = b;
    exp_alert = 0;
    if (v) model_byte(b, s);
  endtask

  task automatic send(string s, bit start);
    for (int i = 0; i < s.len(); i++) step(1, start && i == 0, s[i]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00);
  endtask

  task automatic load(string seg, bit head, int link, bit last, int rule);
    int h;
    h = ref_hash(seg);
    @(negedge clk);
    compare();
    byte_valid = 0; exp_alert = 0;
    wr_en = 1; wr_addr = ADDR_W'(h); wr_valid = 1; wr_head = head;
    wr_link = ADDR_W'(link); wr_last = last; wr_rule = RULE_W'(rule);
    for (int k = 0; k < SEG_LEN; k++) wr_seg[8*k +: 8] = seg[k];
    m_vld[h] = 1; m_head[h] = head; m_link[h] = link; m_last[h] = last;
    m_rule[h] = rule; m_seg[h] = seg;
    @(negedge clk);
    compare();
    wr_en = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL %s: watchdog expired, actual=running expected=finished", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_vld[i] = 0; m_head[i] = 0; m_last[i] = 0; m_link[i] = 0; m_rule[i] = 0; m_seg[i] = "";
    end
    // R1: reset state, and empty memory matches nothing
    cur_req = "R1";
    repeat (3) step(0, 0, 8'h00);
    rst_n = 1;
    idle(2);
    send("GET /", 1);
    send("/bin/echo;", 1);
    idle(2);

    // R2: load table (segment byte k at wr_seg[8k+7:8k])
    cur_req = "R2";
    load("/bin/", 1, 0, 0, 0);
    load("echo;", 0, ref_hash("/bin/"), 1, 3);
    load("kill;", 0, ref_hash("/bin/"), 1, 7);
    load("GET /", 1, 0, 1, 20);
    load("in/ab", 1, 0, 1, 30);
    load("/usr/", 1, 0, 0, 0);
    load("local", 0, ref_hash("/usr/"), 0, 0);
    load("/bin.", 0, ref_hash("local"), 1, 200);
    idle(2);

    cur_req = "R4"; send("GET /", 1); idle(2);
    cur_req = "R4"; send("xyzGET /q", 1); idle(2);
    cur_req = "R5"; send("/bin/echo;", 1); idle(2);
    cur_req = "R6"; send("/bin/kill;", 1); idle(2);
    cur_req = "R5"; send("/usr/local/bin.", 1); idle(2);
    cur_req = "R5"; send("/usr/local/bin/", 1); idle(2);
    cur_req = "R7"; send("/bin/kilX;", 1); idle(2);
    cur_req = "R7"; send("/bin/GET /", 1); idle(2);
    cur_req = "R7"; send("/bin//bin/echo;", 1); idle(2);
    cur_req = "R8"; send("/bin/abxyz", 1); idle(2);
    cur_req = "R8"; send("xin/ab", 1); idle(2);
    cur_req = "R9"; send("/bin/", 1); send("echo;", 1); idle(2);
    cur_req = "R9"; send("GE", 1); send("T /", 1); idle(2);
    cur_req = "R10"; hdr_match[20] = 0; send("GET /", 1); idle(2);
    hdr_match[200] = 0; send("/usr/local/bin.", 1); idle(2);
    hdr_match = '1;
    cur_req = "R11";
    step(1, 1, "/"); idle(3); send("bin/", 0); idle(1);
    send("ec", 0); idle(4); send("ho;", 0); idle(2);
    cur_req = "R2"; load("kill;", 0, ref_hash("/bin/"), 1, 9);
    send("/bin/kill;", 1); idle(2);

    // R3: random bytes from the signature alphabet
    cur_req = "R3";
    begin
      string alpha;
      alpha = "/binechoklGET ;usrab.X";
      for (int n = 0; n < 4000; n++) begin
        bit st;
        int r;
        st = ($urandom_range(0, 39) == 0);
        if (st) for (int j = 0; j < NUM_RULES / 32; j++) hdr_match[32*j +: 32] = $urandom | $urandom;
        r = $urandom_range(0, 9);
        if (r == 0) step(0, 0, 8'h00);
        else step(1, st, alpha[$urandom_range(0, alpha.len() - 1)]);
      end
    end
    idle(3);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule